// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives a clause-22 management bus to a PHY from a single register write. Software first sets a control register that enables the port and picks an MDC clock ratio. It then writes one 32-bit management word that holds the whole frame: start pattern, opcode, PHY address, register address, turnaround code and 16 data bits. The block clocks a 32-bit preamble of ones out on MDIO, followed by the word MSB first. While it runs, a status bit reads 0.

On a read opcode the block stops driving MDIO for the turnaround and data bits. It samples the PHY on each rising MDC edge during the data bits, and it writes the 16 received bits into the low half of the management word when the frame ends. MDC runs only during a transfer. Each MDC period lasts 8, 16, 32 or 64 system clocks, so the bus can be kept within its rate limit for system clocks up to 20, 40 or 80 MHz, or faster.

Register port, selected by `addr_i`:
- 0 is control: bit 0 enables the port, bits 2:1 select the ratio.
- 1 is the management word.
- 2 is status: bit 0 is idle.
- Any other address reads as zero.

Top module: `mdio_frame_master`

## Requirements
- R1: A write to address 1 while the port is enabled and idle starts a frame. Status bit 0 reads 0 from the next cycle for exactly 64 × N cycles, then reads 1 again.
- R2: The MDC period is N = 8 << ctrl[2:1] system clocks (ratio codes 0..3 give 8, 16, 32 and 64). MDC stays low whenever no frame is in progress.
- R3: A frame has 64 MDC periods. MDIO carries 32 ones, then management word bits 31 down to 0. MDIO changes only after a falling MDC edge, so each bit is stable at the rising edge.
- R4: If word bits 29:28 equal 2'b10 (read), output-enable is released for the last 18 bits (turnaround and data). Otherwise output-enable is held for all 64 bits. Output-enable is low while idle.
- R5: On a read, `mdio_i` is sampled at the rising MDC edge of frame bits 48 to 63. When the frame ends, the sampled bits replace word bits 15:0, first sample in bit 15. Word bits 31:16 are kept.
- R6: A write to address 1 while a frame is in progress is ignored. The stored word and the bits on MDIO are unchanged.
- R7: With ctrl[0] = 0, a write to address 1 stores the word but starts no frame. Status stays idle and MDC stays low.
- R8: A frame with a non-read opcode leaves the stored management word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 control, 1 management, 2 status |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Read data of the selected register (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data in |

## Verification
The tests run a write frame at the fastest ratio and again at the slowest ratio. Together they show that both the frame length and the MDC period scale with the ratio code, and that the preamble and word bits leave in the right order. A read frame at ratio 16 uses PHY data that is not a byte pattern and not symmetric. It shows the point where output-enable is released, the sampling edge, and the bit order and placement of the captured data. A write during a frame, and a write with the port disabled, are each followed by a readback of the word and a look at MDC and status. These two show that the write is ignored while busy, and that disabling the port suppresses the start without suppressing the store.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int MGMT_W    = 32;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + MGMT_W;
  localparam int BIT_W     = $clog2(FRAME_LEN);
  localparam int DATA_W    = 16;
  localparam int RATIO_MIN = 8;
  localparam int RATIO_MAX = 64;
  localparam int CNT_W     = $clog2(RATIO_MAX);
  // word bits ahead of turnaround: start(2) op(2) phy(5) reg(5)
  localparam int TA_POS    = 14;
  localparam int OP_HI     = 29;
  localparam int OP_LO     = 28;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_MGMT = 2'd1,
    REG_STAT = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/mdio_clk_gen.sv
`timescale 1ns/1ps
module mdio_clk_gen
  import mdio_pkg::*;
#(
  parameter int CW   = CNT_W,
  parameter int RMIN = RATIO_MIN
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  output logic       mdc_o,
  output logic       rise_o,
  output logic       fall_o
);
  logic [CW:0]   ratio;
  logic [CW-1:0] mask, half, phase, cnt_q;

  assign ratio = (CW+1)'(RMIN) << sel_i;
  assign mask  = CW'(ratio - 1'b1);
  assign half  = CW'(ratio >> 1);
  assign phase = cnt_q & mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // low half first, high half second
  assign mdc_o  = run_i && ((phase & half) != '0);
  assign rise_o = run_i && (phase == half - CW'(1));
  assign fall_o = run_i && (phase == mask);
endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MGMT_W-1:0] word_i,
  input  logic [1:0]        sel_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        sel_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_LEN - 1);
  localparam logic [BIT_W-1:0] BODY_BIT = BIT_W'(PRE_LEN);
  localparam logic [BIT_W-1:0] REL_BIT  = BIT_W'(PRE_LEN + TA_POS);
  localparam logic [BIT_W-1:0] SAMP_BIT = BIT_W'(PRE_LEN + TA_POS + 2);

  logic              busy_q, rd_q;
  logic [1:0]        sel_q;
  logic [MGMT_W-1:0] sh_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] rdata_q;
  logic              in_body;

  assign in_body = bit_q >= BODY_BIT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      sel_q   <= '0;
      sh_q    <= '0;
      bit_q   <= '0;
      rdata_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      sel_q  <= sel_i;
      sh_q   <= word_i;
      bit_q  <= '0;
      rd_q   <= (word_i[OP_HI:OP_LO] == OP_READ);
    end else if (busy_q) begin
      if (rise_i && rd_q && bit_q >= SAMP_BIT)
        rdata_q <= {rdata_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (bit_q == LAST_BIT) busy_q <= 1'b0;
        else                   bit_q  <= bit_q + 1'b1;
        if (in_body) sh_q <= sh_q << 1;
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = busy_q && fall_i && (bit_q == LAST_BIT);
  assign sel_o     = sel_q;
  assign mdio_o    = (busy_q && in_body) ? sh_q[MGMT_W-1] : 1'b1;
  assign mdio_oe_o = busy_q && !(rd_q && bit_q >= REL_BIT);
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/mdio_frame_master.sv
`timescale 1ns/1ps
module mdio_frame_master
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic [2:0]        ctrl_q;
  logic [MGMT_W-1:0] mgmt_q;
  logic              busy, done, rise, fall, wr_mgmt, start;
  logic [1:0]        run_sel;
  logic [DATA_W-1:0] rdata;

  assign wr_mgmt = wr_en_i && (addr_i == REG_MGMT) && !busy;
  assign start   = wr_mgmt && ctrl_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mgmt_q <= '0;
    end else begin
      if (wr_en_i && addr_i == REG_CTRL) ctrl_q <= wr_data_i[2:0];
      if (wr_mgmt) mgmt_q <= wr_data_i;
      else if (done && mgmt_q[OP_HI:OP_LO] == OP_READ)
        mgmt_q[DATA_W-1:0] <= rdata;
    end
  end

  always_comb begin
    case (addr_i)
      REG_CTRL: rd_data_o = {29'b0, ctrl_q};
      REG_MGMT: rd_data_o = mgmt_q;
      REG_STAT: rd_data_o = {31'b0, !busy};
      default:  rd_data_o = '0;
    endcase
  end

  mdio_clk_gen u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .sel_i  (run_sel),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .word_i    (wr_data_i),
    .sel_i     (ctrl_q[2:1]),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .done_o    (done),
    .sel_o     (run_sel),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .rdata_o   (rdata)
  );
endmodule

// File: rtl/mdio_frame_master_chk.sv
`timescale 1ns/1ps
module mdio_frame_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [1:0]  addr_i,
  input logic        mdc_o,
  input logic        mdio_oe_o,
  input logic        busy,
  input logic        done,
  input logic        ctrl_en,
  input logic [31:0] mgmt_q
);
  assert_start_by_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wr_en_i && addr_i == 2'd1 && ctrl_en));

  assert_mdc_quiet_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);

  assert_oe_only_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> busy);

  assert_busy_write_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done && wr_en_i && addr_i == 2'd1) |=> mgmt_q == $past(mgmt_q));

  assert_disabled_no_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !ctrl_en) |=> !busy);
endmodule

bind mdio_frame_master mdio_frame_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .mdc_o     (mdc_o),
  .mdio_oe_o (mdio_oe_o),
  .busy      (busy),
  .done      (done),
  .ctrl_en   (ctrl_q[0]),
  .mgmt_q    (mgmt_q)
);

// File: tb/mdio_frame_master_bench.sv
`timescale 1ns/1ps
module mdio_frame_master_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  int          checks = 0, fails = 0;
  int          rc = 0;
  longint      cyc = 0;
  longint      rise_t [0:1];
  logic        cap_d  [0:63];
  logic        cap_oe [0:63];
  logic [15:0] phy_data = '0;

  mdio_frame_master u_mdio_frame_master (.*);

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;

  // PHY model: record each bit at rising MDC, present the next read bit
  always @(posedge mdc_o) begin
    if (rc < 64) begin
      cap_d[rc]  = mdio_o;
      cap_oe[rc] = mdio_oe_o;
    end
    if (rc < 2) rise_t[rc] = cyc;
    rc++;
    mdio_i = (rc >= 48 && rc < 64) ? phy_data[63-rc] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rd_data_o;
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                     input logic [4:0] ra, input logic [1:0] ta,
                                     input logic [15:0] d);
    return {2'b01, op, phy, ra, ta, d};
  endfunction

  // start a frame, count idle-low cycles, optionally write again mid-frame
  task automatic run_xfer(input logic [31:0] word, input logic [1:0] sel,
                          input bit intr, input logic [31:0] intr_word,
                          output int n);
    reg_wr(2'd0, {29'b0, sel, 1'b1});
    rc = 0;
    mdio_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 2'd1; wr_data_i = word;
    @(negedge clk_i);
    wr_en_i = 1'b0; addr_i = 2'd2;
    n = 0;
    #1;
    while (!rd_data_o[0] && n < 10000) begin
      n++;
      @(negedge clk_i);
      if (intr && n == 100) begin
        wr_en_i = 1'b1; addr_i = 2'd1; wr_data_i = intr_word;
        @(negedge clk_i);
        wr_en_i = 1'b0; addr_i = 2'd2;
        n++;
      end
      #1;
    end
  endtask

  task automatic check_frame(input logic [31:0] word, input bit is_rd,
                             input logic [1:0] sel, input string req_d, input string req_oe);
    int bad_d = 0, bad_oe = 0;
    for (int r = 0; r < 64; r++) begin
      logic ed, eo;
      eo = !(is_rd && r >= 46);
      ed = (r < 32) ? 1'b1 : word[63-r];
      if (cap_oe[r] !== eo) bad_oe++;
      if (eo && cap_d[r] !== ed) bad_d++;
    end
    chk(rc == 64, "R3", "mdc rising edges", rc, 64);
    chk(bad_d == 0, req_d, "mdio bit mismatches", bad_d, 0);
    chk(bad_oe == 0, req_oe, "output-enable mismatches", bad_oe, 0);
    chk(rise_t[1] - rise_t[0] == (8 << sel), "R2", "mdc period",
        rise_t[1] - rise_t[0], 8 << sel);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    reg_rd(2'd0, v); chk(v == 0, "R7", "ctrl after reset", v, 0);
    reg_rd(2'd2, v); chk(v == 1, "R1", "status idle after reset", v, 1);
    chk(mdc_o == 0, "R2", "mdc after reset", mdc_o, 0);
    chk(mdio_oe_o == 0, "R4", "oe after reset", mdio_oe_o, 0);
  endtask

  task automatic t_write_fast;
    logic [31:0] w, v; int n;
    w = mk(2'b01, 5'h0A, 5'h13, 2'b10, 16'hA5C3);
    run_xfer(w, 2'd0, 1'b0, '0, n);
    chk(n == 512, "R1", "busy cycles at ratio 8", n, 512);
    check_frame(w, 1'b0, 2'd0, "R3", "R4");
    reg_rd(2'd1, v); chk(v == w, "R8", "word after write frame", v, w);
    chk(mdc_o == 0, "R2", "mdc after frame", mdc_o, 0);
  endtask

  task automatic t_read;
    logic [31:0] w, v, e; int n;
    w = mk(2'b10, 5'h1F, 5'h00, 2'b00, 16'h0000);
    phy_data = 16'hC3A9;
    run_xfer(w, 2'd1, 1'b0, '0, n);
    chk(n == 1024, "R1", "busy cycles at ratio 16", n, 1024);
    check_frame(w, 1'b1, 2'd1, "R3", "R4");
    e = {w[31:16], 16'hC3A9};
    reg_rd(2'd1, v); chk(v == e, "R5", "read data captured", v, e);
  endtask

  task automatic t_busy_write;
    logic [31:0] w, v; int n;
    w = mk(2'b01, 5'h05, 5'h1C, 2'b10, 16'h3E71);
    run_xfer(w, 2'd2, 1'b1, 32'hFFFF_FFFF, n);
    chk(n == 2048, "R6", "busy cycles with mid-frame write", n, 2048);
    check_frame(w, 1'b0, 2'd2, "R6", "R4");
    reg_rd(2'd1, v); chk(v == w, "R6", "word after mid-frame write", v, w);
  endtask

  task automatic t_disabled;
    logic [31:0] w, v;
    w = mk(2'b01, 5'h11, 5'h02, 2'b10, 16'h1234);
    reg_wr(2'd0, 32'h0);
    rc = 0;
    reg_wr(2'd1, w);
    repeat (40) @(negedge clk_i);
    reg_rd(2'd2, v); chk(v == 1, "R7", "status while disabled", v, 1);
    chk(rc == 0, "R7", "mdc edges while disabled", rc, 0);
    reg_rd(2'd1, v); chk(v == w, "R7", "word stored while disabled", v, w);
  endtask

  task automatic t_write_slow;
    logic [31:0] w, v; int n;
    w = mk(2'b01, 5'h16, 5'h09, 2'b10, 16'h8001);
    run_xfer(w, 2'd3, 1'b0, '0, n);
    chk(n == 4096, "R1", "busy cycles at ratio 64", n, 4096);
    check_frame(w, 1'b0, 2'd3, "R3", "R4");
    reg_rd(2'd1, v); chk(v == w, "R8", "word after slow write", v, w);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_write_fast();
    t_read();
    t_busy_write();
    t_disabled();
    t_write_slow();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule